// File: doc/BRIEF.md
# Sound Processor Watchdog with Reset Request

This block guards a sound processor against a main CPU that has stopped servicing it. A down-counter is armed from a configured length. Each rising edge on the kick input, a non-maskable interrupt from the main CPU, rearms the counter with that length. Each rising edge on the periodic tick input counts it down by one. If the count runs out, the block raises a registered reset request that drives the main CPU's reset line. The request stays high until the block is reset.

A heartbeat output changes level on every tick the block accepts, so the timer can be watched at a pin. When the block comes out of reset, the reset request output drives a single-cycle high pulse between two low levels, marking initialisation. In normal operation the kicks arrive about every half video frame, far sooner than a length such as 0x0800 or 0x1000 ticks would expire.

Top module: `sound_watchdog`

## Requirements
- R1: While rst_n is low, cpu_rst_req and heartbeat are both 0.
- R2: After rst_n goes high, cpu_rst_req is 1 for exactly the first clock cycle and then returns to 0. The counter is loaded from load_val as that pulse ends. Kick and tick edges that occur during those first two cycles have no effect.
- R3: A rising edge on kick during normal operation reloads the counter with the current load_val.
- R4: A rising edge on tick during normal operation decrements the counter by one. The tick that finds the counter at 1 raises cpu_rst_req one cycle later. After a load of N with no further kicks, the Nth tick therefore causes the expiry.
- R5: When a kick edge and a tick edge arrive in the same cycle, the counter is reloaded and not decremented.
- R6: heartbeat inverts on every accepted tick edge, including one that arrives together with a kick, and holds its level otherwise.
- R7: Kick and tick are edge-detected. An input held high for many cycles counts as a single event.
- R8: Once cpu_rst_req has been raised by expiry, it stays 1 until rst_n goes low. Later kicks and ticks change neither cpu_rst_req nor heartbeat.
- R9: A load value of 0 behaves like 1: the first tick after the load expires the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Rearm interrupt from the main CPU; its rising edge reloads the counter |
| tick | input | 1 | Periodic timer; its rising edge counts the counter down |
| load_val | input | CNT_W | Configured timeout length in ticks |
| cpu_rst_req | output | 1 | Registered reset request to the main CPU, also carries the start-up pulse |
| heartbeat | output | 1 | Changes level on each accepted tick |

## Verification
The assertions check four behaviours on every cycle:
- each kick edge leaves the counter at the sampled load value;
- each lone tick edge takes exactly one off the count;
- heartbeat changes level only after a tick;
- a request that has been high for two cycles stays high, and a falling request only ever ends the start-up pulse.

Three behaviours are visible only at the ports, so only the directed scenarios can show them. The first is how many ticks a given load takes to expire, including after a coincident kick and tick. The second is that a held input counts once. The third is that the start-up window and the expired state ignore their inputs.

// File: rtl/sound_watchdog.sv
module sound_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             cpu_rst_req,
  output logic             heartbeat
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [1:0] {ST_ARM, ST_PULSE, ST_RUN, ST_DEAD} wd_state_t;

  wd_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic             kick_q, tick_q, req_q, hb_q;
  logic             kick_ev, tick_ev, running, expire;

  assign kick_ev     = kick & ~kick_q;
  assign tick_ev     = tick & ~tick_q;
  assign running     = (st == ST_RUN);
  assign expire      = running & tick_ev & ~kick_ev & (cnt <= CNT_ONE);
  assign cpu_rst_req = req_q;
  assign heartbeat   = hb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_ARM;
      cnt    <= '0;
      kick_q <= 1'b0;
      tick_q <= 1'b0;
      req_q  <= 1'b0;
      hb_q   <= 1'b0;
    end else begin
      kick_q <= kick;
      tick_q <= tick;
      case (st)
        ST_ARM: begin
          st    <= ST_PULSE;
          req_q <= 1'b1;
        end
        ST_PULSE: begin
          st    <= ST_RUN;
          req_q <= 1'b0;
          cnt   <= load_val;
        end
        ST_RUN: begin
          if (kick_ev)      cnt <= load_val;
          else if (tick_ev) cnt <= cnt - CNT_ONE;
          if (tick_ev)      hb_q <= ~hb_q;
          if (expire) begin
            st    <= ST_DEAD;
            req_q <= 1'b1;
          end
        end
        ST_DEAD: ;
        default: st <= ST_ARM;
      endcase
    end
  end

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && kick_ev) |=> (cnt == $past(load_val)));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_ev && !kick_ev) |=> (cnt == $past(cnt) - CNT_ONE));

  assert_hb_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_ev) |=> (heartbeat != $past(heartbeat)));

  assert_hb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && tick_ev) |=> $stable(heartbeat));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_req && $past(cpu_rst_req)) |=> cpu_rst_req);

  assert_pulse_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_req) |-> running);

endmodule

// File: tb/sound_watchdog_bench.sv
module sound_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] load_val = 16'd4;
  logic        cpu_rst_req, heartbeat;
  int          n_chk = 0, n_bad = 0;
  logic        hb_exp = 1'b0;

  always #10 clk = ~clk;

  sound_watchdog #(.CNT_W(16)) u_sound_watchdog (
    .clk(clk), .rst_n(rst_n), .kick(kick), .tick(tick), .load_val(load_val),
    .cpu_rst_req(cpu_rst_req), .heartbeat(heartbeat));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] len, input logic poke_init);
    rst_n = 1'b0; kick = 1'b0; tick = 1'b0; load_val = len;
    repeat (3) @(negedge clk);
    check("R1 req in reset", cpu_rst_req, 1'b0);
    check("R1 hb in reset", heartbeat, 1'b0);
    rst_n = 1'b1;
    if (poke_init) begin tick = 1'b1; kick = 1'b1; end
    @(negedge clk);
    tick = 1'b0; kick = 1'b0;
    check("R2 pulse high", cpu_rst_req, 1'b1);
    @(negedge clk);
    check("R2 pulse low", cpu_rst_req, 1'b0);
    hb_exp = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic k, input logic t);
    kick = k; tick = t;
    @(negedge clk);
    kick = 1'b0; tick = 1'b0;
    if (t) hb_exp = ~hb_exp;
    @(negedge clk);
  endtask

  task automatic run_ticks(input int n, input logic req_after, input string req);
    for (int i = 0; i < n; i++) pulse(1'b0, 1'b1);
    check(req, cpu_rst_req, req_after);
    check("R6 heartbeat", heartbeat, hb_exp);
  endtask

  task automatic t_count;
    do_reset(16'd5, 1'b0);
    run_ticks(4, 1'b0, "R4 no expiry before 5th tick");
    run_ticks(1, 1'b1, "R4 expiry on 5th tick");
  endtask

  task automatic t_zero;
    do_reset(16'd0, 1'b0);
    run_ticks(1, 1'b1, "R9 zero load expires first tick");
  endtask

  task automatic t_kick;
    do_reset(16'd5, 1'b0);
    run_ticks(4, 1'b0, "R3 before kick");
    load_val = 16'd3;
    pulse(1'b1, 1'b0);
    run_ticks(2, 1'b0, "R3 reload holds off expiry");
    run_ticks(1, 1'b1, "R3 expiry after reload length");
  endtask

  task automatic t_same;
    do_reset(16'd3, 1'b0);
    run_ticks(2, 1'b0, "R5 pre");
    pulse(1'b1, 1'b1);
    check("R6 hb on coincident tick", heartbeat, hb_exp);
    run_ticks(2, 1'b0, "R5 kick wins over tick");
    run_ticks(1, 1'b1, "R5 expiry after full reload");
  endtask

  task automatic t_hold;
    do_reset(16'd3, 1'b0);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0; hb_exp = ~hb_exp;
    @(negedge clk);
    check("R7 held tick counts once", heartbeat, hb_exp);
    run_ticks(1, 1'b0, "R7 held tick counts once req");
    run_ticks(1, 1'b1, "R7 expiry on 3rd event");
  endtask

  task automatic t_init_ignore;
    do_reset(16'd2, 1'b1);
    check("R2 init tick ignored hb", heartbeat, 1'b0);
    run_ticks(1, 1'b0, "R2 init events ignored");
    run_ticks(1, 1'b1, "R2 expiry after full length");
  endtask

  task automatic t_dead;
    logic hb_now;
    do_reset(16'd1, 1'b0);
    run_ticks(1, 1'b1, "R8 expired");
    hb_now = heartbeat;
    pulse(1'b1, 1'b0);
    check("R8 kick ignored", cpu_rst_req, 1'b1);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
    check("R8 ticks ignored req", cpu_rst_req, 1'b1);
    check("R8 hb frozen", heartbeat, hb_now);
    pulse(1'b1, 1'b1);
    check("R8 still asserted", cpu_rst_req, 1'b1);
  endtask

  task automatic t_long;
    do_reset(16'h0040, 1'b0);
    run_ticks(63, 1'b0, "R4 long count before end");
    run_ticks(1, 1'b1, "R4 long count expiry");
  endtask

  initial begin
    t_count();
    t_zero();
    t_kick();
    t_same();
    t_hold();
    t_init_ignore();
    t_dead();
    t_long();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule